// File: doc/BRIEF.md
# Region CRC Checker Register Bank

This block is the software-visible register bank that sits beside a display region CRC checker. It holds the checker's global run enable and the four display-signal polarity selects. For each region of interest it keeps an enable, a one-way lock, the top-left and bottom-right corner coordinates and a 32-bit expected signature. It also keeps the status flags and the interrupt masks. The checker core reports through two kinds of single-cycle set pulses: one says that a frame's results are ready, and one per region says that the region's signature did not match. The bank turns the flags and the masks into a single interrupt line.

Software reaches every register through a plain word-addressed bus. A write is taken on any cycle with `bus_en` and `bus_we` high. A read request (`bus_en` high, `bus_we` low) loads `bus_rdata` on the next rising edge, and the value holds until the next read. The bus has no back-pressure: every request is accepted in the cycle it is presented. The word map is fixed. CTRL is at 0x00, with bit0 the run enable and bits 4:1 the polarity selects. INTC is at 0x01, with bit0 the results-ready mask, bit1 the mismatch mask and bit2 the freeze. STAT is at 0x02, with bit0 results-ready, bit1 the error summary and bit 16+r the mismatch flag of region r. Region r owns four words starting at 0x10+4r: +0 holds enable (bit0) and lock (bit1), +1 holds the top-left corner, +2 holds the bottom-right corner and +3 holds the expected CRC. A corner word carries X in bits XW-1:0 and Y in bits 16+YW-1:16.

Top module: `crcchk_regbank`

## Requirements
- R1: After reset, CTRL, STAT, every region word, `chk_enable`, `chk_polarity`, `roi_enable` and `irq` are zero, and INTC reads 0x3 (both interrupts masked, not frozen).
- R2: A write to CTRL stores bit0 as the run enable and bits 4:1 as the polarity selects. Both appear at the outputs after the write edge and read back with all other bits zero.
- R3: A pulse on `evt_done` sets STAT bit0. Writing 1 to STAT bit0 clears it. When the pulse and the clearing write arrive in the same cycle, the flag ends up set.
- R4: A pulse on `evt_mismatch[r]` sets STAT bit 16+r. Writing 1 to that bit clears only that bit. When a pulse and a clear for the same bit arrive in the same cycle, the pulse wins.
- R5: STAT bit1 reads 1 exactly when at least one mismatch bit is set, and it drops only when the last set mismatch bit is cleared. Writes to bit1 have no effect.
- R6: `irq` = (STAT bit0 AND NOT INTC bit0) OR (STAT bit1 AND NOT INTC bit1). A mask bit of 1 blocks its source.
- R7: Once INTC bit2 is written 1, it stays 1 and INTC bits 1:0 ignore all later writes until reset. The write that sets bit2 also stores the mask bits that come with it.
- R8: An unlocked region's enable, corners and expected CRC are stored on write, appear on the region outputs and read back at their word offsets.
- R9: Writing 1 to a region's lock bit freezes that region's enable, lock and corner words against all writes until reset. The region's expected CRC stays writable.
- R10: The expected CRC of an enabled region can be rewritten, and the region stays enabled.
- R11: Reads return data on `bus_rdata` one edge after the request. Addresses 0x03–0x0F, and region slots at or above NREG, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, loaded one edge after a read request |
| evt_done | input | 1 | Core pulse: frame results ready |
| evt_mismatch | input | NREG | Core pulses: per-region signature mismatch |
| chk_enable | output | 1 | Global run enable to the core |
| chk_polarity | output | 4 | Polarity selects: frame sync, line sync, data valid, sample edge |
| roi_enable | output | NREG | Per-region enables |
| roi_x0 | output | NREG*XW | Top-left X, region r at [r*XW +: XW] |
| roi_y0 | output | NREG*YW | Top-left Y, region r at [r*YW +: YW] |
| roi_x1 | output | NREG*XW | Bottom-right X |
| roi_y1 | output | NREG*YW | Bottom-right Y |
| roi_ref | output | NREG*CRCW | Expected CRC per region |
| irq | output | 1 | Combined interrupt |

## Verification
A register write or a core pulse changes the stored state and every output that depends on it, `irq` included, at the first rising edge after the stimulus. A read's data is loaded on the first rising edge after the request. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge, so every value is observed in the cycle it is due. The sweeps cover every mismatch pattern for four regions, every combination of mask and flag for the interrupt, and all 32 CTRL values. The same-cycle collisions of a set pulse with a clear are driven inside a single cycle.

// File: rtl/crcchk_regs_pkg.sv
package crcchk_regs_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned INTC_ADDR   = 1;
  localparam int unsigned STAT_ADDR   = 2;
  localparam int unsigned REGION_BASE = 16;
  localparam int unsigned STAT_MIS_LSB = 16;

  // word offsets inside one region slot
  localparam logic [1:0] SUB_CFG = 2'd0;
  localparam logic [1:0] SUB_UL  = 2'd1;
  localparam logic [1:0] SUB_LR  = 2'd2;
  localparam logic [1:0] SUB_REF = 2'd3;
endpackage

// File: rtl/crcchk_ctrl_regs.sv
module crcchk_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_intc,
  input  logic       wd_enable,
  input  logic [3:0] wd_pol,
  input  logic       wd_fmask,
  input  logic       wd_emask,
  input  logic       wd_freeze,
  output logic       run_en,
  output logic [3:0] pol,
  output logic       fmask,
  output logic       emask,
  output logic       freeze
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      pol    <= '0;
    end else if (wr_ctrl) begin
      run_en <= wd_enable;
      pol    <= wd_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmask  <= 1'b1;
      emask  <= 1'b1;
      freeze <= 1'b0;
    end else if (wr_intc) begin
      if (!freeze) begin
        fmask <= wd_fmask;
        emask <= wd_emask;
      end
      freeze <= freeze | wd_freeze;
    end
  end

  assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (freeze && $stable(fmask) && $stable(emask)));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (run_en == $past(wd_enable)) && (pol == $past(wd_pol)));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(run_en) && $stable(pol));
endmodule

// File: rtl/crcchk_status_regs.sv
module crcchk_status_regs #(
  parameter int unsigned NREG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_done,
  input  logic [NREG-1:0] evt_mis,
  input  logic            clr_en,
  input  logic            clr_func,
  input  logic [NREG-1:0] clr_mis,
  output logic            func_flag,
  output logic [NREG-1:0] mis_flags,
  output logic            err_flag
);
  logic [NREG-1:0] clr_mask;
  assign clr_mask = clr_en ? clr_mis : '0;

  // set pulse dominates a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_flag <= 1'b0;
      mis_flags <= '0;
    end else begin
      func_flag <= evt_done | (func_flag & ~(clr_en & clr_func));
      mis_flags <= evt_mis | (mis_flags & ~clr_mask);
    end
  end

  assign err_flag = |mis_flags;

  assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> func_flag);

  assert_func_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_func && !evt_done) |=> !func_flag);

  assert_mis_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_mis) |=> ((mis_flags & $past(evt_mis)) == $past(evt_mis)));

  assert_mis_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_mis) |=> err_flag);

  assert_err_drop_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(clr_en));
endmodule

// File: rtl/crcchk_region.sv
module crcchk_region #(
  parameter int unsigned XW   = 13,
  parameter int unsigned YW   = 12,
  parameter int unsigned CRCW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_cfg,
  input  logic            wr_ul,
  input  logic            wr_lr,
  input  logic            wr_ref,
  input  logic            wd_en,
  input  logic            wd_lock,
  input  logic [XW-1:0]   wd_x,
  input  logic [YW-1:0]   wd_y,
  input  logic [CRCW-1:0] wd_ref,
  output logic            en,
  output logic            lock,
  output logic [XW-1:0]   x0,
  output logic [YW-1:0]   y0,
  output logic [XW-1:0]   x1,
  output logic [YW-1:0]   y1,
  output logic [CRCW-1:0] ref_crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      lock <= 1'b0;
      x0   <= '0;
      y0   <= '0;
      x1   <= '0;
      y1   <= '0;
    end else if (!lock) begin
      if (wr_cfg) begin
        en   <= wd_en;
        lock <= wd_lock;
      end
      if (wr_ul) begin
        x0 <= wd_x;
        y0 <= wd_y;
      end
      if (wr_lr) begin
        x1 <= wd_x;
        y1 <= wd_y;
      end
    end
  end

  // the expected signature is outside the lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_crc <= '0;
    else if (wr_ref) ref_crc <= wd_ref;
  end

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (lock && $stable(en) && $stable(x0) && $stable(y0)
              && $stable(x1) && $stable(y1)));

  assert_ref_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |=> ref_crc == $past(wd_ref));

  assert_ref_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ref |=> $stable(ref_crc));
endmodule

// File: rtl/crcchk_regbank.sv
module crcchk_regbank #(
  parameter int unsigned NREG   = 4,
  parameter int unsigned XW     = 13,
  parameter int unsigned YW     = 12,
  parameter int unsigned CRCW   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 evt_done,
  input  logic [NREG-1:0]      evt_mismatch,
  output logic                 chk_enable,
  output logic [3:0]           chk_polarity,
  output logic [NREG-1:0]      roi_enable,
  output logic [NREG*XW-1:0]   roi_x0,
  output logic [NREG*YW-1:0]   roi_y0,
  output logic [NREG*XW-1:0]   roi_x1,
  output logic [NREG*YW-1:0]   roi_y1,
  output logic [NREG*CRCW-1:0] roi_ref,
  output logic                 irq
);
  import crcchk_regs_pkg::*;

  localparam int unsigned IW = ADDR_W - 2;

  // ---------------- address decode ----------------
  logic wr, rd;
  logic hit_ctrl, hit_intc, hit_stat, rhit;
  logic [ADDR_W-1:0] roff;
  logic [IW-1:0]     ridx;
  logic [1:0]        rsub;

  assign wr       = bus_en & bus_we;
  assign rd       = bus_en & ~bus_we;
  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign hit_intc = (bus_addr == ADDR_W'(INTC_ADDR));
  assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
  assign roff     = bus_addr - ADDR_W'(REGION_BASE);
  assign ridx     = roff[ADDR_W-1:2];
  assign rsub     = roff[1:0];
  assign rhit     = (bus_addr >= ADDR_W'(REGION_BASE)) && (ridx < IW'(NREG));

  // ---------------- control and interrupt masks ----------------
  logic fmask, emask, freeze;

  crcchk_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr && hit_ctrl),
    .wr_intc   (wr && hit_intc),
    .wd_enable (bus_wdata[0]),
    .wd_pol    (bus_wdata[4:1]),
    .wd_fmask  (bus_wdata[0]),
    .wd_emask  (bus_wdata[1]),
    .wd_freeze (bus_wdata[2]),
    .run_en    (chk_enable),
    .pol       (chk_polarity),
    .fmask     (fmask),
    .emask     (emask),
    .freeze    (freeze)
  );

  // ---------------- status ----------------
  logic            func_flag, err_flag;
  logic [NREG-1:0] mis_flags;

  crcchk_status_regs #(.NREG(NREG)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_done  (evt_done),
    .evt_mis   (evt_mismatch),
    .clr_en    (wr && hit_stat),
    .clr_func  (bus_wdata[0]),
    .clr_mis   (bus_wdata[STAT_MIS_LSB +: NREG]),
    .func_flag (func_flag),
    .mis_flags (mis_flags),
    .err_flag  (err_flag)
  );

  assign irq = (func_flag & ~fmask) | (err_flag & ~emask);

  // ---------------- regions ----------------
  logic            en_a   [NREG];
  logic            lock_a [NREG];
  logic [XW-1:0]   x0_a   [NREG];
  logic [YW-1:0]   y0_a   [NREG];
  logic [XW-1:0]   x1_a   [NREG];
  logic [YW-1:0]   y1_a   [NREG];
  logic [CRCW-1:0] ref_a  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_roi
    logic sel;
    assign sel = wr && rhit && (ridx == IW'(g));

    crcchk_region #(.XW(XW), .YW(YW), .CRCW(CRCW)) u_roi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cfg  (sel && (rsub == SUB_CFG)),
      .wr_ul   (sel && (rsub == SUB_UL)),
      .wr_lr   (sel && (rsub == SUB_LR)),
      .wr_ref  (sel && (rsub == SUB_REF)),
      .wd_en   (bus_wdata[0]),
      .wd_lock (bus_wdata[1]),
      .wd_x    (bus_wdata[XW-1:0]),
      .wd_y    (bus_wdata[16 +: YW]),
      .wd_ref  (bus_wdata[CRCW-1:0]),
      .en      (en_a[g]),
      .lock    (lock_a[g]),
      .x0      (x0_a[g]),
      .y0      (y0_a[g]),
      .x1      (x1_a[g]),
      .y1      (y1_a[g]),
      .ref_crc (ref_a[g])
    );

    assign roi_enable[g]             = en_a[g];
    assign roi_x0[g*XW +: XW]        = x0_a[g];
    assign roi_y0[g*YW +: YW]        = y0_a[g];
    assign roi_x1[g*XW +: XW]        = x1_a[g];
    assign roi_y1[g*YW +: YW]        = y1_a[g];
    assign roi_ref[g*CRCW +: CRCW]   = ref_a[g];
  end

  // ---------------- read path ----------------
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (hit_ctrl) begin
      rd_word[0]   = chk_enable;
      rd_word[4:1] = chk_polarity;
    end else if (hit_intc) begin
      rd_word[2:0] = {freeze, emask, fmask};
    end else if (hit_stat) begin
      rd_word[0] = func_flag;
      rd_word[1] = err_flag;
      rd_word[STAT_MIS_LSB +: NREG] = mis_flags;
    end else if (rhit) begin
      for (int r = 0; r < NREG; r++) begin
        if (ridx == IW'(r)) begin
          case (rsub)
            SUB_CFG: rd_word[1:0] = {lock_a[r], en_a[r]};
            SUB_UL: begin
              rd_word[XW-1:0]  = x0_a[r];
              rd_word[16 +: YW] = y0_a[r];
            end
            SUB_LR: begin
              rd_word[XW-1:0]  = x1_a[r];
              rd_word[16 +: YW] = y1_a[r];
            end
            default: rd_word[CRCW-1:0] = ref_a[r];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_word;
  end

  assert_irq_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (func_flag && !fmask) |-> irq);

  assert_irq_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !emask) |-> irq);

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_flag && !err_flag) |-> !irq);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rhit && (bus_addr > ADDR_W'(STAT_ADDR))) |=> (bus_rdata == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_crcchk_regbank.sv
module tb_crcchk_regbank;
  localparam int NREG = 4;
  localparam int XW   = 13;
  localparam int YW   = 12;
  localparam int CRCW = 32;
  localparam int AW   = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 bus_en = 1'b0;
  logic                 bus_we = 1'b0;
  logic [AW-1:0]        bus_addr = '0;
  logic [31:0]          bus_wdata = '0;
  logic [31:0]          bus_rdata;
  logic                 evt_done = 1'b0;
  logic [NREG-1:0]      evt_mismatch = '0;
  logic                 chk_enable;
  logic [3:0]           chk_polarity;
  logic [NREG-1:0]      roi_enable;
  logic [NREG*XW-1:0]   roi_x0, roi_x1;
  logic [NREG*YW-1:0]   roi_y0, roi_y1;
  logic [NREG*CRCW-1:0] roi_ref;
  logic                 irq;

  crcchk_regbank #(.NREG(NREG), .XW(XW), .YW(YW), .CRCW(CRCW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(evt_done), .evt_mismatch(evt_mismatch),
    .chk_enable(chk_enable), .chk_polarity(chk_polarity),
    .roi_enable(roi_enable), .roi_x0(roi_x0), .roi_y0(roi_y0),
    .roi_x1(roi_x1), .roi_y1(roi_y1), .roi_ref(roi_ref), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic dn, input logic [NREG-1:0] mm);
    @(negedge clk);
    evt_done = dn; evt_mismatch = mm;
    @(negedge clk);
    evt_done = 1'b0; evt_mismatch = '0;
  endtask

  function automatic logic [31:0] corner(input int x, input int y);
    return (32'(y % (1 << YW)) << 16) | 32'(x % (1 << XW));
  endfunction

  function automatic logic [AW-1:0] raddr(input int r, input int sub);
    return AW'(16 + 4 * r + sub);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 enable", 32'({chk_polarity, chk_enable}), 0);
    chk("R1 roi_enable", 32'(roi_enable), 0);
    rd(AW'(0), d); chk("R1 ctrl", d, 0);
    rd(AW'(1), d); chk("R1 intc", d, 3);
    rd(AW'(2), d); chk("R1 stat", d, 0);
    for (int r = 0; r < NREG; r++) begin
      for (int s = 0; s < 4; s++) begin
        rd(raddr(r, s), d); chk("R1 region word", d, 0);
      end
    end

    // R2 control sweep
    for (int v = 0; v < 32; v++) begin
      wr(AW'(0), 32'(v) | 32'hFFFF_FFE0);
      chk("R2 outputs", 32'({chk_polarity, chk_enable}), 32'(v));
      rd(AW'(0), d); chk("R2 readback", d, 32'(v));
    end
    wr(AW'(0), 0);

    // R3 results-ready flag
    pulse(1'b1, '0);
    rd(AW'(2), d); chk("R3 set", d, 1);
    wr(AW'(2), 1);
    rd(AW'(2), d); chk("R3 w1c", d, 0);
    pulse(1'b1, '0);
    wr(AW'(2), 0);
    rd(AW'(2), d); chk("R3 zero write keeps", d, 1);
    @(negedge clk);
    evt_done = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(2); bus_wdata = 1;
    @(negedge clk);
    evt_done = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    rd(AW'(2), d); chk("R3 set beats clear", d, 1);
    wr(AW'(2), 1);

    // R4 / R5 mismatch sweep
    for (int m = 1; m < 16; m++) begin
      int keep;
      keep = m & ~5;
      pulse(1'b0, NREG'(m));
      rd(AW'(2), d); chk("R4 mismatch set / R5 err", d, (32'(m) << 16) | 2);
      wr(AW'(2), (32'd5 << 16) | 32'd2);
      rd(AW'(2), d);
      chk("R4 partial clear / R5 err", d, (32'(keep) << 16) | ((keep != 0) ? 32'd2 : 32'd0));
      wr(AW'(2), 32'hF << 16);
      rd(AW'(2), d); chk("R5 err drops", d, 0);
    end
    pulse(1'b0, 4'b0100);
    @(negedge clk);
    evt_mismatch = 4'b0100; bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(2); bus_wdata = 32'h4 << 16;
    @(negedge clk);
    evt_mismatch = '0; bus_en = 1'b0; bus_we = 1'b0;
    rd(AW'(2), d); chk("R4 set beats clear", d, (32'h4 << 16) | 2);
    wr(AW'(2), 2);
    rd(AW'(2), d); chk("R5 err write ignored", d, (32'h4 << 16) | 2);
    wr(AW'(2), 32'hF << 16);
    wr(AW'(2), 2);
    rd(AW'(2), d); chk("R5 err write no set", d, 0);

    // R6 interrupt masking
    for (int c = 0; c < 16; c++) begin
      logic fm, em, ff, ef;
      fm = c[0]; em = c[1]; ff = c[2]; ef = c[3];
      wr(AW'(1), {30'd0, em, fm});
      if (ff || ef) pulse(ff, ef ? 4'b0010 : 4'b0000);
      chk("R6 irq", 32'(irq), 32'((ff & ~fm) | (ef & ~em)));
      wr(AW'(2), 32'hFFFF_0001);
      chk("R6 irq after clear", 32'(irq), 0);
    end
    wr(AW'(1), 3);

    // R8 region configuration
    for (int r = 0; r < NREG; r++) begin
      wr(raddr(r, 0), 1);
      wr(raddr(r, 1), corner(100 * r + 5, 50 * r + 3));
      wr(raddr(r, 2), corner(1000 + 7 * r, 600 + 11 * r));
      wr(raddr(r, 3), 32'hA500_0000 ^ (32'(r) * 32'h0101_0101));
    end
    for (int r = 0; r < NREG; r++) begin
      chk("R8 enable", 32'(roi_enable[r]), 1);
      chk("R8 x0", 32'(roi_x0[r*XW +: XW]), 32'(100 * r + 5));
      chk("R8 y0", 32'(roi_y0[r*YW +: YW]), 32'(50 * r + 3));
      chk("R8 x1", 32'(roi_x1[r*XW +: XW]), 32'(1000 + 7 * r));
      chk("R8 y1", 32'(roi_y1[r*YW +: YW]), 32'(600 + 11 * r));
      chk("R8 ref", roi_ref[r*CRCW +: CRCW], 32'hA500_0000 ^ (32'(r) * 32'h0101_0101));
      rd(raddr(r, 0), d); chk("R8 cfg readback", d, 1);
      rd(raddr(r, 1), d); chk("R8 ul readback", d, corner(100 * r + 5, 50 * r + 3));
      rd(raddr(r, 2), d); chk("R8 lr readback", d, corner(1000 + 7 * r, 600 + 11 * r));
      rd(raddr(r, 3), d); chk("R8 ref readback", d, 32'hA500_0000 ^ (32'(r) * 32'h0101_0101));
    end

    // R9 lock
    wr(raddr(1, 0), 3);
    rd(raddr(1, 0), d); chk("R9 lock readback", d, 3);
    wr(raddr(1, 0), 0);
    wr(raddr(1, 1), corner(8191, 4095));
    wr(raddr(1, 2), corner(1, 2));
    chk("R9 enable held", 32'(roi_enable[1]), 1);
    chk("R9 x0 held", 32'(roi_x0[XW +: XW]), 105);
    chk("R9 y1 held", 32'(roi_y1[YW +: YW]), 611);
    rd(raddr(1, 0), d); chk("R9 cfg held", d, 3);
    rd(raddr(1, 1), d); chk("R9 ul held", d, corner(105, 53));
    wr(raddr(1, 3), 32'hDEAD_BEEF);
    chk("R9 ref writable", roi_ref[CRCW +: CRCW], 32'hDEAD_BEEF);
    wr(raddr(2, 0), 0);
    chk("R9 unlocked disables", 32'(roi_enable[2]), 0);

    // R10 reference rewrite while enabled
    wr(raddr(0, 3), 32'h1234_5678);
    chk("R10 ref", roi_ref[CRCW-1:0], 32'h1234_5678);
    chk("R10 still enabled", 32'(roi_enable[0]), 1);

    // R11 unmapped space
    rd(AW'(5), d); chk("R11 hole", d, 0);
    rd(AW'(3), d); chk("R11 hole 3", d, 0);
    wr(AW'(16 + 4 * NREG), 32'hFFFF_FFFF);
    wr(AW'(16 + 4 * NREG + 3), 32'hFFFF_FFFF);
    rd(AW'(16 + 4 * NREG), d); chk("R11 beyond regions", d, 0);
    chk("R11 no side effect", 32'(roi_enable), 32'b1011);
    chk("R11 ref untouched", roi_ref[3*CRCW +: CRCW], 32'hA500_0000 ^ 32'h0303_0303);

    // R7 freeze (last: it sticks until reset)
    pulse(1'b1, '0);
    wr(AW'(1), 4);
    chk("R7 irq unmasked", 32'(irq), 1);
    wr(AW'(1), 3);
    rd(AW'(1), d); chk("R7 masks frozen", d, 4);
    chk("R7 irq still", 32'(irq), 1);
    wr(AW'(1), 0);
    rd(AW'(1), d); chk("R7 freeze sticks", d, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule